// File: doc/BRIEF.md
# Core Power Domain Sequencer

The sequencer turns the switchable supply of one of several processor cores on or off, one strictly ordered step at a time. Every core has a seven-bit control word and an L1 memory power-down request. The two-stage power switches, logic isolation, SRAM isolation, SRAM clock isolation, clock gating and active-low reset in that word are all driven from here. The sequencer waits on two power-good status vectors, a per-core L1 acknowledge and a per-core idle indication. A settle delay of about 1 µs is produced by a counter of `CLK_MHZ` cycles.

A request is made in two parts. First comes an unlock write whose upper half carries the key 0x0B16 and whose bit 0 is 1. Then comes a command giving the core index, the direction and an optional wait-for-idle. One accepted command consumes one unlock. A command without a pending unlock, or one that arrives while a sequence runs, is dropped and pulses `err`. `busy` covers the whole sequence and `done` pulses once at its end.

States are `S_IDLE`, `S_IDLE_WAIT`, power-up `U_SW1`, `U_DLY_A`, `U_SW2`, `U_PG_ON`, `U_ISO`, `U_L1`, `U_L1_ACK`, `U_DLY_B`, `U_SRAM`, `U_CKISO`, `U_CLKON`, `U_RST`, and power-down `D_ISO`, `D_CKISO`, `D_SRAM`, `D_L1`, `D_L1_ACK`, `D_RST`, `D_CLKOFF`, `D_SW1`, `D_SW2`, `D_PG_OFF`. The transitions are as follows:
- An accepted command leaves `S_IDLE` for `U_SW1` when it asks for power-on. It goes to `S_IDLE_WAIT` for power-off with the idle wait, and to `D_ISO` otherwise.
- `S_IDLE_WAIT` moves on when the idle bit is set.
- `U_DLY_A` and `U_DLY_B` move on when the counter expires.
- `U_PG_ON` moves on when both status bits are 1, and `D_PG_OFF` when both are 0.
- `U_L1_ACK` moves on when the acknowledge is low, and `D_L1_ACK` when it is high.
- Every other state advances unconditionally to the next one in its list.
- `U_RST` and `D_PG_OFF` return to `S_IDLE`.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, core 0 reads control word 0x4D (bit 0 reset_n=1, bit 1 iso=0, bit 2 switch1=1, bit 3 switch2=1, bit 4 clock-off=0, bit 5 SRAM clock iso=0, bit 6 SRAM iso_n=1) with L1 request 0. Every other core reads 0x32 with L1 request 1. busy, done and err are 0.
- R2: A command is accepted only if an unlock write with unlock_word[31:16]=0x0B16 and unlock_word[0]=1 came before it. Otherwise it changes no control bit and err is 1 in the following cycle.
- R3: An accepted command consumes the unlock, so the next command needs a new unlock. A rejected command leaves a pending unlock in place.
- R4: Power-up makes exactly these changes, in this order: switch1 to 1, switch2 to 1, iso to 0, L1 request to 0, SRAM iso_n to 1, SRAM clock iso to 0, clock-off to 0, reset_n to 1. switch2 follows switch1 by at least CLK_MHZ cycles.
- R5: During power-up, logic isolation is released only once bit (13 - core) is 1 in both pwr_stat_a and pwr_stat_b.
- R6: On power-up, after the L1 request is cleared, the sequence waits for l1_ack to go low and then at least CLK_MHZ more cycles. On power-down, after the L1 request is set, it waits for l1_ack to go high.
- R7: Power-down makes exactly these changes, in this order: iso to 1, SRAM clock iso to 1, SRAM iso_n to 0, L1 request to 1, reset_n to 0, clock-off to 1, switch1 to 0, switch2 to 0. It then waits until both status bits for the core are 0.
- R8: With wait-for-idle set, power-down changes nothing until idle_stat bit (16 + core) is 1.
- R9: Only one sequence runs at a time, and a command that arrives while busy is ignored with err. At most one control bit changes per cycle, and only on the addressed core.
- R10: busy is 1 from the cycle after acceptance until completion. done is a one-cycle pulse that appears while busy is 0.
- R11: If an unlock and a command arrive in the same cycle, the command is judged only on the earlier unlock state. The new unlock stays pending for the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock_valid | input | 1 | Unlock write strobe |
| unlock_word | input | 32 | Unlock data, key in [31:16], enable in [0] |
| cmd_valid | input | 1 | Command strobe |
| cmd_core | input | CI_W | Target core index |
| cmd_on | input | 1 | 1 = power up, 0 = power down |
| cmd_wait_idle | input | 1 | Power-down waits for the core's idle bit |
| pwr_stat_a | input | 32 | Primary power-good status, core c at bit 13-c |
| pwr_stat_b | input | 32 | Secondary power-good status, core c at bit 13-c |
| idle_stat | input | 32 | Core idle indication, core c at bit 16+c |
| l1_ack | input | NCORE | L1 power-down acknowledge per core |
| core_ctl | output | NCORE*7 | Control words, core c at [7c+6:7c] |
| l1_pdn_req | output | NCORE | L1 power-down request per core |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The unlock path can be hit twice in one cycle: an unlock write and a command can land on the same edge. This happens both when no earlier unlock is pending and when one is. The bench drives both strobes together from the same negative clock edge. It expects a rejection with err in the first case and an accepted command in the second. In each case it then issues a bare command and expects acceptance, because the same-cycle unlock must still be pending.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int          CTL_W       = 7;
    localparam logic [15:0] UNLOCK_KEY  = 16'h0B16;
    localparam int          PG_TOP      = 13;
    localparam int          IDLE_BASE   = 16;

    // bit positions inside the 8-bit per-core word (bit 7 = L1 request)
    localparam logic [2:0] B_RSTN      = 3'd0;
    localparam logic [2:0] B_ISO       = 3'd1;
    localparam logic [2:0] B_SW1       = 3'd2;
    localparam logic [2:0] B_SW2       = 3'd3;
    localparam logic [2:0] B_CLKOFF    = 3'd4;
    localparam logic [2:0] B_CKISO     = 3'd5;
    localparam logic [2:0] B_SRAMISO_N = 3'd6;
    localparam logic [2:0] B_L1REQ     = 3'd7;

    localparam logic [7:0] WORD_ON  = 8'h4D;
    localparam logic [7:0] WORD_OFF = 8'hB2;

    typedef enum logic [4:0] {
        S_IDLE, S_IDLE_WAIT,
        U_SW1, U_DLY_A, U_SW2, U_PG_ON, U_ISO, U_L1, U_L1_ACK, U_DLY_B,
        U_SRAM, U_CKISO, U_CLKON, U_RST,
        D_ISO, D_CKISO, D_SRAM, D_L1, D_L1_ACK, D_RST, D_CLKOFF,
        D_SW1, D_SW2, D_PG_OFF
    } seq_state_t;

endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
    parameter int CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cps_gate.sv
module cps_gate (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        unlock_valid,
    input  logic [31:0] unlock_word,
    input  logic        cmd_valid,
    input  logic        seq_busy,
    output logic        accept,
    output logic        err
);
    import cps_pkg::*;

    logic armed;
    logic key_ok;
    logic unused_word;

    assign key_ok      = unlock_valid && (unlock_word[31:16] == UNLOCK_KEY) && unlock_word[0];
    assign accept      = cmd_valid && armed && !seq_busy;
    assign unused_word = ^unlock_word[15:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            err   <= 1'b0;
        end else begin
            if (key_ok)
                armed <= 1'b1;
            else if (accept)
                armed <= 1'b0;
            err <= cmd_valid && !accept;
        end
    end
endmodule

// File: rtl/cps_bank.sv
module cps_bank #(
    parameter int NCORE = 4,
    parameter int CI_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_en,
    input  logic [CI_W-1:0]           op_core,
    input  logic [2:0]                op_bit,
    input  logic                      op_val,
    output logic [NCORE*cps_pkg::CTL_W-1:0] ctl,
    output logic [NCORE-1:0]          l1req
);
    import cps_pkg::*;

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        logic [7:0] word;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word <= (g == 0) ? WORD_ON : WORD_OFF;
            else if (op_en && (op_core == CI_W'(g)))
                word[op_bit] <= op_val;
        end

        assign ctl[g*CTL_W +: CTL_W] = word[CTL_W-1:0];
        assign l1req[g]              = word[7];
    end
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm #(
    parameter int NCORE = 4,
    parameter int CI_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CI_W-1:0]  cmd_core,
    input  logic             cmd_on,
    input  logic             cmd_wait,
    input  logic [31:0]      pg_a,
    input  logic [31:0]      pg_b,
    input  logic [31:0]      idle_st,
    input  logic [NCORE-1:0] l1_ack,
    input  logic             tmr_exp,
    output logic             tmr_start,
    output logic             op_en,
    output logic [CI_W-1:0]  op_core,
    output logic [2:0]       op_bit,
    output logic             op_val,
    output logic             busy,
    output logic             done
);
    import cps_pkg::*;

    seq_state_t      state, nxt;
    logic [CI_W-1:0] cur_core;
    logic [4:0]      pg_idx, idle_idx;
    logic            pg_on, pg_off, idle_ok, ack;

    assign pg_idx   = 5'(PG_TOP) - 5'(cur_core);
    assign idle_idx = 5'(IDLE_BASE) + 5'(cur_core);
    assign pg_on    = pg_a[pg_idx] && pg_b[pg_idx];
    assign pg_off   = !pg_a[pg_idx] && !pg_b[pg_idx];
    assign idle_ok  = idle_st[idle_idx];
    assign ack      = l1_ack[cur_core];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_core <= '0;
            done     <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && accept)
                cur_core <= cmd_core;
            done <= (state == U_RST) || (state == D_PG_OFF && pg_off);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (accept) nxt = cmd_on ? U_SW1 : (cmd_wait ? S_IDLE_WAIT : D_ISO);
            S_IDLE_WAIT: if (idle_ok) nxt = D_ISO;
            U_SW1:       nxt = U_DLY_A;
            U_DLY_A:     if (tmr_exp) nxt = U_SW2;
            U_SW2:       nxt = U_PG_ON;
            U_PG_ON:     if (pg_on) nxt = U_ISO;
            U_ISO:       nxt = U_L1;
            U_L1:        nxt = U_L1_ACK;
            U_L1_ACK:    if (!ack) nxt = U_DLY_B;
            U_DLY_B:     if (tmr_exp) nxt = U_SRAM;
            U_SRAM:      nxt = U_CKISO;
            U_CKISO:     nxt = U_CLKON;
            U_CLKON:     nxt = U_RST;
            U_RST:       nxt = S_IDLE;
            D_ISO:       nxt = D_CKISO;
            D_CKISO:     nxt = D_SRAM;
            D_SRAM:      nxt = D_L1;
            D_L1:        nxt = D_L1_ACK;
            D_L1_ACK:    if (ack) nxt = D_RST;
            D_RST:       nxt = D_CLKOFF;
            D_CLKOFF:    nxt = D_SW1;
            D_SW1:       nxt = D_SW2;
            D_SW2:       nxt = D_PG_OFF;
            D_PG_OFF:    if (pg_off) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    always_comb begin
        op_en     = 1'b0;
        op_bit    = B_RSTN;
        op_val    = 1'b0;
        tmr_start = 1'b0;
        unique case (state)
            U_SW1:    begin op_en = 1'b1; op_bit = B_SW1;       op_val = 1'b1; tmr_start = 1'b1; end
            U_SW2:    begin op_en = 1'b1; op_bit = B_SW2;       op_val = 1'b1; end
            U_ISO:    begin op_en = 1'b1; op_bit = B_ISO;       op_val = 1'b0; end
            U_L1:     begin op_en = 1'b1; op_bit = B_L1REQ;     op_val = 1'b0; end
            U_L1_ACK: tmr_start = !ack;
            U_SRAM:   begin op_en = 1'b1; op_bit = B_SRAMISO_N; op_val = 1'b1; end
            U_CKISO:  begin op_en = 1'b1; op_bit = B_CKISO;     op_val = 1'b0; end
            U_CLKON:  begin op_en = 1'b1; op_bit = B_CLKOFF;    op_val = 1'b0; end
            U_RST:    begin op_en = 1'b1; op_bit = B_RSTN;      op_val = 1'b1; end
            D_ISO:    begin op_en = 1'b1; op_bit = B_ISO;       op_val = 1'b1; end
            D_CKISO:  begin op_en = 1'b1; op_bit = B_CKISO;     op_val = 1'b1; end
            D_SRAM:   begin op_en = 1'b1; op_bit = B_SRAMISO_N; op_val = 1'b0; end
            D_L1:     begin op_en = 1'b1; op_bit = B_L1REQ;     op_val = 1'b1; end
            D_RST:    begin op_en = 1'b1; op_bit = B_RSTN;      op_val = 1'b0; end
            D_CLKOFF: begin op_en = 1'b1; op_bit = B_CLKOFF;    op_val = 1'b1; end
            D_SW1:    begin op_en = 1'b1; op_bit = B_SW1;       op_val = 1'b0; end
            D_SW2:    begin op_en = 1'b1; op_bit = B_SW2;       op_val = 1'b0; end
            default:  ;
        endcase
    end

    assign op_core = cur_core;
    assign busy    = (state != S_IDLE);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq #(
    parameter int NCORE   = 4,
    parameter int CLK_MHZ = 250,
    localparam int CI_W   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 unlock_valid,
    input  logic [31:0]          unlock_word,
    input  logic                 cmd_valid,
    input  logic [CI_W-1:0]      cmd_core,
    input  logic                 cmd_on,
    input  logic                 cmd_wait_idle,
    input  logic [31:0]          pwr_stat_a,
    input  logic [31:0]          pwr_stat_b,
    input  logic [31:0]          idle_stat,
    input  logic [NCORE-1:0]     l1_ack,
    output logic [NCORE*7-1:0]   core_ctl,
    output logic [NCORE-1:0]     l1_pdn_req,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    localparam int DLY_CYC = CLK_MHZ;

    logic            accept, tmr_start, tmr_exp, op_en, op_val;
    logic [CI_W-1:0] op_core;
    logic [2:0]      op_bit;

    cps_gate u_gate (
        .clk(clk), .rst_n(rst_n), .unlock_valid(unlock_valid), .unlock_word(unlock_word),
        .cmd_valid(cmd_valid), .seq_busy(busy), .accept(accept), .err(err)
    );

    cps_timer #(.CYCLES(DLY_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .expired(tmr_exp)
    );

    cps_fsm #(.NCORE(NCORE), .CI_W(CI_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_core(cmd_core), .cmd_on(cmd_on),
        .cmd_wait(cmd_wait_idle), .pg_a(pwr_stat_a), .pg_b(pwr_stat_b), .idle_st(idle_stat),
        .l1_ack(l1_ack), .tmr_exp(tmr_exp), .tmr_start(tmr_start), .op_en(op_en),
        .op_core(op_core), .op_bit(op_bit), .op_val(op_val), .busy(busy), .done(done)
    );

    cps_bank #(.NCORE(NCORE), .CI_W(CI_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_core(op_core), .op_bit(op_bit),
        .op_val(op_val), .ctl(core_ctl), .l1req(l1_pdn_req)
    );

    assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({core_ctl, l1_pdn_req} ^ $past({core_ctl, l1_pdn_req})) <= 1);
    assert_start_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(accept));
endmodule

// File: tb/core_pwr_seq_test.sv
`timescale 1ns/1ps
module core_pwr_seq_test;
    localparam int NC  = 4;
    localparam int DLY = 250;
    localparam logic [31:0] GOOD_KEY = 32'h0B16_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unlock_valid = 1'b0;
    logic [31:0] unlock_word = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_core = '0;
    logic        cmd_on = 1'b0;
    logic        cmd_wait_idle = 1'b0;
    logic [31:0] pg_a = 32'h0000_2000;
    logic [31:0] pg_b = 32'h0000_2000;
    logic [31:0] idle_stat = '0;
    logic [NC-1:0] l1_ack = 4'b1110;
    logic [NC*7-1:0] core_ctl;
    logic [NC-1:0] l1_pdn_req;
    logic busy, done, err;

    always #2 clk = ~clk;

    core_pwr_seq #(.NCORE(NC), .CLK_MHZ(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .unlock_valid(unlock_valid), .unlock_word(unlock_word),
        .cmd_valid(cmd_valid), .cmd_core(cmd_core), .cmd_on(cmd_on), .cmd_wait_idle(cmd_wait_idle),
        .pwr_stat_a(pg_a), .pwr_stat_b(pg_b), .idle_stat(idle_stat), .l1_ack(l1_ack),
        .core_ctl(core_ctl), .l1_pdn_req(l1_pdn_req), .busy(busy), .done(done), .err(err)
    );

    int n_tests = 0, n_fail = 0, cyc = 0, multi_chg = 0, ev_n = 0;
    int ev_code [512];
    int ev_core [512];
    int ev_time [512];
    logic [7:0] prev_w [NC];
    bit mstate [NC];
    bit hold_b = 1'b0;
    bit finished = 1'b0;
    int lag [NC];

    always @(posedge clk) cyc++;

    function automatic logic [7:0] word_now(int c);
        return {l1_pdn_req[c], core_ctl[c*7 +: 7]};
    endfunction

    function automatic logic [7:0] exp_word(bit on);
        return on ? 8'h4D : 8'hB2;
    endfunction

    // event code = bit*2 + new value
    function automatic int exp_code(bit on, int k);
        int up [8] = '{5, 7, 2, 14, 13, 10, 8, 1};
        int dn [8] = '{3, 11, 12, 15, 0, 9, 4, 6};
        return on ? up[k] : dn[k];
    endfunction

    // change recorder
    always @(negedge clk) begin : rec
        int nchg;
        logic [7:0] w;
        nchg = 0;
        for (int c = 0; c < NC; c++) begin
            w = word_now(c);
            if (rst_n) begin
                for (int b = 0; b < 8; b++) begin
                    if (w[b] != prev_w[c][b]) begin
                        nchg++;
                        if (ev_n < 512) begin
                            ev_code[ev_n] = b * 2 + int'(w[b]);
                            ev_core[ev_n] = c;
                            ev_time[ev_n] = cyc;
                        end
                        ev_n++;
                    end
                end
            end
            prev_w[c] = w;
        end
        if (nchg > 1) multi_chg++;
    end

    // power switch and L1 model with random lag
    always @(negedge clk) begin : model
        bit tgt;
        for (int c = 0; c < NC; c++) begin
            if (lag[c] != 0) lag[c]--;
            else begin
                tgt = core_ctl[c*7 + 2] & core_ctl[c*7 + 3];
                pg_a[13 - c] = tgt;
                if (!hold_b) pg_b[13 - c] = tgt;
                l1_ack[c] = l1_pdn_req[c];
                lag[c] = int'($urandom % 4);
            end
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_unlock(input logic [31:0] w);
        unlock_valid = 1'b1; unlock_word = w;
        tick;
        unlock_valid = 1'b0; unlock_word = '0;
    endtask

    task automatic send_cmd(input int c, input bit on, input bit wt);
        cmd_valid = 1'b1; cmd_core = 2'(c); cmd_on = on; cmd_wait_idle = wt;
        tick;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (!done && k < 5000) begin tick; k++; end
        chk(done == 1'b1, "R10", {req, " done pulse seen"}, int'(done), 1);
        chk(busy == 1'b0, "R10", "busy low with done", int'(busy), 0);
        tick;
        chk(done == 1'b0, "R10", "done lasts one cycle", int'(done), 0);
    endtask

    task automatic check_seq(input int st, input int c, input bit on);
        int bad;
        bad = 0;
        chk(ev_n - st == 8, on ? "R4" : "R7", "step count", ev_n - st, 8);
        for (int k = 0; k < 8; k++)
            if (st + k < ev_n && (ev_core[st+k] != c || ev_code[st+k] != exp_code(on, k))) bad++;
        chk(bad == 0, on ? "R4" : "R7", "step order mismatches", bad, 0);
        if (on) begin
            chk(ev_time[st+1] - ev_time[st] >= DLY, "R4", "switch gap", ev_time[st+1] - ev_time[st], DLY);
            chk(ev_time[st+4] - ev_time[st+3] >= DLY, "R6", "L1 settle gap", ev_time[st+4] - ev_time[st+3], DLY);
            chk(l1_ack[c] == 1'b0, "R6", "ack low after power-up", int'(l1_ack[c]), 0);
        end else begin
            chk(l1_ack[c] == 1'b1, "R6", "ack high after power-down", int'(l1_ack[c]), 1);
            chk(!pg_a[13-c] && !pg_b[13-c], "R7", "status cleared at done", int'(pg_a[13-c] | pg_b[13-c]), 0);
        end
    endtask

    task automatic check_words(input string req);
        for (int c = 0; c < NC; c++)
            chk(word_now(c) == exp_word(mstate[c]), req, "core word", int'(word_now(c)), int'(exp_word(mstate[c])));
    endtask

    task automatic run_op(input int c, input bit on, input bit wt, input bit unl, input int idle_dly);
        int st;
        if (unl) do_unlock(GOOD_KEY);
        st = ev_n;
        send_cmd(c, on, wt);
        chk(!err && busy, on ? "R4" : "R7", "command accepted", int'(busy), 1);
        if (wt && !on) begin
            repeat (idle_dly) tick;
            chk(ev_n == st, "R8", "no step before idle", ev_n - st, 0);
            idle_stat[16 + c] = 1'b1;
        end
        wait_done(on ? "R4" : "R7");
        check_seq(st, c, on);
        idle_stat = '0;
        mstate[c] = on;
        check_words("R9");
    endtask

    initial begin : main
        int st;
        void'($urandom(32'd7731));
        for (int c = 0; c < NC; c++) begin mstate[c] = (c == 0); lag[c] = 0; end
        repeat (5) tick;
        rst_n = 1'b1;
        tick;

        // R1 reset values
        check_words("R1");
        chk(!busy && !done && !err, "R1", "status idle", int'({busy, done, err}), 0);

        // R2 command with no unlock
        st = ev_n;
        send_cmd(1, 1'b1, 1'b0);
        chk(err == 1'b1, "R2", "err without unlock", int'(err), 1);
        chk(busy == 1'b0, "R2", "no start without unlock", int'(busy), 0);
        repeat (4) tick;
        chk(ev_n == st, "R2", "no change without unlock", ev_n - st, 0);

        // R2 wrong key and missing enable bit
        do_unlock(32'h0B17_0001);
        send_cmd(1, 1'b1, 1'b0);
        chk(err == 1'b1 && !busy, "R2", "wrong key rejected", int'(err), 1);
        do_unlock(32'h0B16_0000);
        send_cmd(1, 1'b1, 1'b0);
        chk(err == 1'b1 && !busy, "R2", "enable bit 0 rejected", int'(err), 1);
        repeat (3) tick;
        chk(ev_n == st, "R2", "rejections left cores alone", ev_n - st, 0);

        // R4 power-up core 1
        run_op(1, 1'b1, 1'b0, 1'b1, 0);

        // R3 unlock consumed
        send_cmd(2, 1'b1, 1'b0);
        chk(err == 1'b1 && !busy, "R3", "second command needs new unlock", int'(err), 1);

        // R9 command while busy; R3 rejected command keeps pending unlock
        do_unlock(GOOD_KEY);
        st = ev_n;
        send_cmd(1, 1'b0, 1'b0);
        repeat (5) tick;
        do_unlock(GOOD_KEY);
        send_cmd(2, 1'b1, 1'b0);
        chk(err == 1'b1, "R9", "busy command flagged", int'(err), 1);
        wait_done("R9");
        check_seq(st, 1, 1'b0);
        mstate[1] = 1'b0;
        check_words("R9");
        run_op(2, 1'b1, 1'b0, 1'b0, 0);

        // R5 secondary status held low
        hold_b = 1'b1;
        do_unlock(GOOD_KEY);
        st = ev_n;
        send_cmd(3, 1'b1, 1'b0);
        repeat (DLY + 60) tick;
        chk(core_ctl[3*7 + 3] == 1'b1, "R5", "second switch on", int'(core_ctl[3*7+3]), 1);
        chk(core_ctl[3*7 + 1] == 1'b1, "R5", "isolation held", int'(core_ctl[3*7+1]), 1);
        chk(ev_n - st == 2, "R5", "stalled after switches", ev_n - st, 2);
        hold_b = 1'b0;
        wait_done("R5");
        check_seq(st, 3, 1'b1);
        mstate[3] = 1'b1;
        check_words("R9");

        // R8 idle wait
        run_op(3, 1'b0, 1'b1, 1'b1, 60);

        // R11 same-cycle unlock and command, nothing pending
        unlock_valid = 1'b1; unlock_word = GOOD_KEY;
        cmd_valid = 1'b1; cmd_core = 2'd2; cmd_on = 1'b0; cmd_wait_idle = 1'b0;
        tick;
        unlock_valid = 1'b0; cmd_valid = 1'b0;
        chk(err == 1'b1 && !busy, "R11", "same-cycle unlock does not serve command", int'(err), 1);
        run_op(2, 1'b0, 1'b0, 1'b0, 0);

        // R11 same-cycle unlock and command, one pending
        do_unlock(GOOD_KEY);
        st = ev_n;
        unlock_valid = 1'b1; unlock_word = GOOD_KEY;
        cmd_valid = 1'b1; cmd_core = 2'd2; cmd_on = 1'b1; cmd_wait_idle = 1'b0;
        tick;
        unlock_valid = 1'b0; cmd_valid = 1'b0;
        chk(!err && busy, "R11", "pending unlock serves command", int'(busy), 1);
        wait_done("R11");
        check_seq(st, 2, 1'b1);
        mstate[2] = 1'b1;
        run_op(1, 1'b1, 1'b0, 1'b0, 0);

        // random operations
        for (int i = 0; i < 12; i++) begin
            int c;
            bit wt;
            c  = int'($urandom % NC);
            wt = 1'($urandom % 2);
            run_op(c, !mstate[c], wt, 1'b1, int'($urandom % 20));
        end

        chk(multi_chg == 0, "R9", "cycles with several bit changes", multi_chg, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule